// File: doc/BRIEF.md
# Presettable Binary Down Counter

This block is a binary down counter, eight bits wide by default. On each rising clock edge it steps down by one while its active-low carry-in is asserted, and it wraps from zero back to the all-ones value. Every control input is active-low. An asynchronous clear forces the count to all ones. An asynchronous preset forces a jam word into the count. A synchronous preset loads the same jam word at the next rising edge. An active-low zero output marks the cycles in which the count is zero while carry-in is asserted.

That zero output is meant to feed the carry-in of the next, more significant stage. A chain of stages then forms a wider down counter in which each higher stage steps only when every stage below it has reached zero. The controls follow a fixed precedence: clear, then asynchronous preset, then synchronous preset, then counting, then hold.

Top module: `preset_down_counter`

## Requirements
- R1: With clr_n, aload_n and sload_n all high and cin_n low, each rising clock edge lowers count_q by one. A count of 0 wraps to 255.
- R2: With clr_n, aload_n, sload_n and cin_n all high, a rising clock edge leaves count_q unchanged.
- R3: With clr_n and aload_n high and sload_n low, the next rising edge loads jam_word into count_q, whatever the level of cin_n.
- R4: While clr_n is high and aload_n is low, count_q equals jam_word without waiting for a clock edge, whatever the levels of sload_n, cin_n and clk. This includes a change of jam_word while aload_n stays low.
- R5: While clr_n is low, count_q reads 255 without waiting for a clock edge, whatever the levels of every other input.
- R6: zero_n is low exactly when count_q is 0 and cin_n is low. This also holds while a forced value from clear or asynchronous preset is showing.
- R7: Once the asynchronous controls are released, the count holds or steps from the value that was forced. After reset through clr_n, the count starts at 255.
- R8: Two stages, where the low stage's zero_n drives the high stage's cin_n, count down as one 16-bit counter. The value is {high count, low count}, and it wraps from 0 to 65535.
- R9: jam_word bit 0 has weight 1 and bit 7 has weight 128. Loading 8'h01 and stepping once gives a count of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear to all ones, active low, highest precedence |
| aload_n | input | 1 | Asynchronous preset from jam_word, active low |
| sload_n | input | 1 | Synchronous preset from jam_word, active low |
| cin_n | input | 1 | Carry-in / count enable, active low |
| jam_word | input | WIDTH | Preset word, bit 0 least significant |
| count_q | output | WIDTH | Current count, including any forced value |
| zero_n | output | 1 | Carry-out / zero detect, active low |

## Verification
The clocked properties assume that clr_n or aload_n, once pulled low, stays low across at least one rising edge. A pulse that opens and closes between two edges would change the count without a sampled cause. They also assume that jam_word does not change at the moment aload_n is released. The stimulus meets both assumptions by changing every input only at the falling clock edge. It mixes weighted random control levels with directed cases at zero, at wrap, under a forced preset, and in a two-stage chain.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

   // Action chosen for a clock edge, listed from lowest to highest precedence
   typedef enum logic [2:0] {
      ACT_HOLD  = 3'd0,
      ACT_DEC   = 3'd1,
      ACT_SYNC  = 3'd2,
      ACT_FORCE = 3'd3,
      ACT_CLEAR = 3'd4
   } dcnt_act_e;

endpackage

// File: rtl/dcnt_arbiter.sv
module dcnt_arbiter
   import dcnt_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clr_n,
   input  logic             aload_n,
   input  logic             sload_n,
   input  logic             cin_n,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] jam,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE_VAL = WIDTH'(1);

   dcnt_act_e act;

   always_comb begin
      if (!clr_n)        act = ACT_CLEAR;
      else if (!aload_n) act = ACT_FORCE;
      else if (!sload_n) act = ACT_SYNC;
      else if (!cin_n)   act = ACT_DEC;
      else               act = ACT_HOLD;
   end

   always_comb begin
      unique case (act)
         ACT_CLEAR: nxt = TOP_VAL;
         ACT_FORCE: nxt = jam;
         ACT_SYNC:  nxt = jam;
         ACT_DEC:   nxt = cur - ONE_VAL;
         default:   nxt = cur;
      endcase
   end

endmodule

// File: rtl/dcnt_state.sv
module dcnt_state #(
   parameter int WIDTH      = 8,
   parameter bit FORCE_VIEW = 1'b1
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             aload_n,
   input  logic [WIDTH-1:0] jam,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] state,
   output logic [WIDTH-1:0] view
);

   localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

   logic [WIDTH-1:0] cnt_r;

   always_ff @(posedge clk or negedge clr_n or negedge aload_n) begin
      if (!clr_n)        cnt_r <= TOP_VAL;
      else if (!aload_n) cnt_r <= jam;
      else               cnt_r <= nxt;
   end

   assign state = cnt_r;

   generate
      if (FORCE_VIEW) begin : g_transparent
         // Forced values show at once and follow jam between edges
         always_comb begin
            if (!clr_n)        view = TOP_VAL;
            else if (!aload_n) view = jam;
            else               view = cnt_r;
         end
      end else begin : g_register_only
         assign view = cnt_r;
      end
   endgenerate

endmodule

// File: rtl/dcnt_zero.sv
module dcnt_zero #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] count,
   input  logic             cin_n,
   output logic             zero_n
);

   logic all_clear;

   assign all_clear = ~|count;
   assign zero_n    = ~(all_clear & ~cin_n);

endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter #(
   parameter int WIDTH      = 8,
   parameter bit FORCE_VIEW = 1'b1
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             aload_n,
   input  logic             sload_n,
   input  logic             cin_n,
   input  logic [WIDTH-1:0] jam_word,
   output logic [WIDTH-1:0] count_q,
   output logic             zero_n
);

   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("preset_down_counter: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] state_w;
   logic [WIDTH-1:0] next_w;

   dcnt_arbiter #(.WIDTH(WIDTH)) u_arb (
      .clr_n   (clr_n),
      .aload_n (aload_n),
      .sload_n (sload_n),
      .cin_n   (cin_n),
      .cur     (state_w),
      .jam     (jam_word),
      .nxt     (next_w)
   );

   dcnt_state #(.WIDTH(WIDTH), .FORCE_VIEW(FORCE_VIEW)) u_state (
      .clk     (clk),
      .clr_n   (clr_n),
      .aload_n (aload_n),
      .jam     (jam_word),
      .nxt     (next_w),
      .state   (state_w),
      .view    (count_q)
   );

   dcnt_zero #(.WIDTH(WIDTH)) u_zero (
      .count   (count_q),
      .cin_n   (cin_n),
      .zero_n  (zero_n)
   );

endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             clr_n,
   input logic             aload_n,
   input logic             sload_n,
   input logic             cin_n,
   input logic [WIDTH-1:0] jam_word,
   input logic [WIDTH-1:0] count_q,
   input logic             zero_n
);

   localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

   // R1
   dec_step_chk: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
      (sload_n && !cin_n) |=> (count_q == WIDTH'($past(count_q) - 1'b1)));

   // R1
   wrap_top_chk: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
      (sload_n && !cin_n && count_q == '0) |=> (count_q == TOP_VAL));

   // R2
   hold_still_chk: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
      (sload_n && cin_n) |=> $stable(count_q));

   // R3
   sync_load_chk: assert property (@(posedge clk) disable iff (!clr_n || !aload_n)
      (!sload_n) |=> (count_q == $past(jam_word)));

   // R6
   zero_low_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (!zero_n) |-> (count_q == '0 && !cin_n));

   // R6
   zero_hit_chk: assert property (@(posedge clk) disable iff (!clr_n)
      (count_q == '0 && !cin_n) |-> !zero_n);

   always @(negedge clk) begin
      if (clr_n === 1'b0) begin
         // R5
         clear_force_chk: assert (count_q == TOP_VAL)
            else $error("clear did not force all ones");
      end else if (clr_n === 1'b1 && aload_n === 1'b0 && !$isunknown(jam_word)) begin
         // R4
         preset_force_chk: assert (count_q == jam_word)
            else $error("async preset not visible");
      end
   end

endmodule

bind preset_down_counter dcnt_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/preset_down_counter_test.sv
module preset_down_counter_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         clr_n, aload_n, sload_n, cin_n;
   logic [W-1:0] jam;
   logic [W-1:0] count_q;
   logic         zero_n;

   // cascade pair
   logic         c_clr_n, c_sload_n, c_cin_n;
   logic [W-1:0] c_jam_lo, c_jam_hi;
   logic [W-1:0] lo_q, hi_q;
   logic         lo_zero_n, hi_zero_n;

   int unsigned  n_chk = 0;
   int unsigned  n_bad = 0;
   logic [W-1:0] m_cnt;
   logic [15:0]  c_val;
   bit           saw_zero16;

   always #4 clk = ~clk;

   preset_down_counter #(.WIDTH(W)) uut (
      .clk(clk), .clr_n(clr_n), .aload_n(aload_n), .sload_n(sload_n),
      .cin_n(cin_n), .jam_word(jam), .count_q(count_q), .zero_n(zero_n)
   );

   preset_down_counter #(.WIDTH(W)) casc_lo (
      .clk(clk), .clr_n(c_clr_n), .aload_n(1'b1), .sload_n(c_sload_n),
      .cin_n(c_cin_n), .jam_word(c_jam_lo), .count_q(lo_q), .zero_n(lo_zero_n)
   );

   preset_down_counter #(.WIDTH(W)) casc_hi (
      .clk(clk), .clr_n(c_clr_n), .aload_n(1'b1), .sload_n(c_sload_n),
      .cin_n(lo_zero_n), .jam_word(c_jam_hi), .count_q(hi_q), .zero_n(hi_zero_n)
   );

   function automatic logic [W-1:0] view_of(input logic [W-1:0] m, input logic c,
                                            input logic a, input logic [W-1:0] j);
      if (!c) return 8'hFF;
      if (!a) return j;
      return m;
   endfunction

   function automatic logic [W-1:0] step_of(input logic [W-1:0] m, input logic c,
                                            input logic a, input logic s, input logic e,
                                            input logic [W-1:0] j);
      if (!c) return 8'hFF;
      if (!a) return j;
      if (!s) return j;
      if (!e) return m - 8'd1;
      return m;
   endfunction

   function automatic string tag_of(input logic c, input logic a, input logic s,
                                    input logic e);
      if (!c) return "R5";
      if (!a) return "R4";
      if (!s) return "R3";
      if (!e) return "R1";
      return "R2";
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
      end
   endtask

   // Drive at the falling edge, check the asynchronous view, then check after the rising edge
   task automatic cycle(input logic c, input logic a, input logic s, input logic e,
                        input logic [W-1:0] j);
      logic [W-1:0] v;
      @(negedge clk);
      clr_n = c; aload_n = a; sload_n = s; cin_n = e; jam = j;
      #1;
      v = view_of(m_cnt, c, a, j);
      check(tag_of(c, a, 1'b1, 1'b1), count_q, v);
      check("R6", zero_n, !(v == 0 && !e));
      @(posedge clk);
      m_cnt = step_of(m_cnt, c, a, s, e, j);
      #1;
      v = view_of(m_cnt, c, a, j);
      check(tag_of(c, a, s, e), count_q, v);
      check("R6", zero_n, !(v == 0 && !e));
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [W-1:0] jv;
      void'($urandom(32'd4711));
      clr_n = 1'b0; aload_n = 1'b1; sload_n = 1'b1; cin_n = 1'b1; jam = '0;
      c_clr_n = 1'b0; c_sload_n = 1'b1; c_cin_n = 1'b1; c_jam_lo = '0; c_jam_hi = '0;
      m_cnt = 8'hFF;

      // R5 reset state
      cycle(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
      cycle(1'b0, 1'b0, 1'b0, 1'b0, 8'h33);
      // R7 release: hold at 255
      cycle(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      check("R7", count_q, 255);
      // R3 sync load with cin high, then R1 down to zero and wrap
      cycle(1'b1, 1'b1, 1'b0, 1'b1, 8'h03);
      check("R3", count_q, 3);
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
      check("R1", count_q, 255);
      // R6 zero with cin high stays inactive
      cycle(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
      cycle(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      check("R6", zero_n, 1);
      // R9 bit order: load 1, step once -> 0
      cycle(1'b1, 1'b1, 1'b0, 1'b1, 8'h01);
      cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
      check("R9", count_q, 0);
      check("R9", zero_n, 0);
      // R4 async preset overriding sync load and cin; jam change while held
      cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A);
      @(negedge clk);
      jam = 8'hA5;
      #1;
      check("R4", count_q, 8'hA5);
      @(posedge clk);
      m_cnt = 8'hA5;
      #1;
      check("R4", count_q, 8'hA5);
      // R6 forced zero with cin low
      cycle(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
      check("R6", zero_n, 0);
      // R5 clear overrides async preset
      cycle(1'b0, 1'b0, 1'b1, 1'b0, 8'h44);
      // R7 resume counting from the forced value
      cycle(1'b1, 1'b0, 1'b1, 1'b1, 8'h10);
      cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h77);
      check("R7", count_q, 8'h0F);

      // constrained random mix
      for (int i = 0; i < 1500; i++) begin
         jv = W'($urandom);
         cycle(($urandom % 100) >= 3, ($urandom % 100) >= 6,
               ($urandom % 100) >= 12, ($urandom % 100) >= 70, jv);
      end

      // R8 two-stage cascade
      @(negedge clk);
      c_clr_n = 1'b1; c_sload_n = 1'b0; c_jam_hi = 8'h01; c_jam_lo = 8'h02;
      @(posedge clk);
      c_val = 16'h0102;
      saw_zero16 = 1'b0;
      #1;
      check("R8", {hi_q, lo_q}, c_val);
      @(negedge clk);
      c_sload_n = 1'b1; c_cin_n = 1'b0;
      for (int i = 0; i < 270; i++) begin
         @(posedge clk);
         c_val = c_val - 16'd1;
         #1;
         check("R8", {hi_q, lo_q}, c_val);
         check("R8", hi_zero_n, !(c_val == 0));
         if (c_val == 0) saw_zero16 = 1'b1;
      end
      check("R8", saw_zero16, 1);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule